// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR-style flash. After a program or erase has been launched elsewhere, a one-cycle `start` pulse hands control to the poller. The poller then reads the flash status word through a request/acknowledge read port. It watches the toggle bit (bit 6) across pairs of reads and consults the timeout bit (bit 5) when the toggle bit is still moving. The outcome is a single-cycle done pulse, together with either a pass pulse or a fail pulse.

A finished operation shows up as a toggle bit that holds its value across a pair of reads. The timeout bit is set when the device ran out of internal pulses. In that case the block makes one more pair of reads, because the toggle bit may have frozen just as the timeout bit rose. If the toggle bit still moves on that confirming pair, the operation is failed. The block then writes the reset command (0x00F0) so that the device goes back to reading array data, and only after the write is acknowledged does it report the failure. An optional limit on toggling pairs that show no timeout also ends the wait with the same failure path. An `abort` input drops everything at any time, and the next `start` always begins with a fresh pair of reads.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `rd_req`, `wr_req`, `busy`, `done`, `pass` and `fail` are all low, and they stay low until `start` is seen.
- R2: A `start` seen while idle raises `busy` and `rd_req` in the next cycle. Each read request is held high until a cycle in which `rd_ack` is high, and `rd_data` is taken in that cycle. Every evaluation uses two such reads: the first one of the pair and the second one.
- R3: If bit 6 of the second read equals bit 6 of the first read, `done` and `pass` are high together for exactly one cycle, in the cycle after the second acknowledge, and the block is idle again. Bits other than 6 and 5 never affect the outcome.
- R4: If bit 6 differs between the two reads and bit 5 of the second read is 0, the block starts a new pair. The first read of the new pair supplies the new reference value.
- R5: If bit 6 differs and bit 5 of the second read is 1, the block makes one confirming pair. If bit 6 is steady on that pair, the result is pass as in R3.
- R6: If bit 6 still differs on the confirming pair, the block holds `wr_req` high with `wr_data` = 16'h00F0 until `wr_ack`. In the cycle after `wr_ack`, `done` and `fail` are high together for exactly one cycle.
- R7: When `MAX_PAIRS` is nonzero, the `MAX_PAIRS`-th consecutive pair that toggles with bit 5 low leads into the reset write and fail report of R6 instead of another pair.
- R8: `abort` returns the block to idle in the next cycle with no done, pass or fail pulse. It overrides a read or write acknowledge, and a `start`, in the same cycle. The discarded reference value is never reused: a later `start` begins with a new first read.
- R9: A `start` seen while the block is busy is ignored.
- R10: `rd_req` and `wr_req` are never high together. `done` is high exactly when one of `pass` or `fail` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (taken only when idle) |
| abort | input | 1 | Abandon polling and return to idle |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | DATA_W | Status word returned by the flash |
| wr_req | output | 1 | Reset-command write request |
| wr_ack | input | 1 | Write acknowledge |
| wr_data | output | DATA_W | Reset command value (0x00F0) |
| busy | output | 1 | Polling or writing in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
Two things can land in the same cycle and pull in different directions: an abort, and the acknowledge that would otherwise settle a read pair or end the reset write. The bench drives `abort` high in the very cycle that carries the second read acknowledge, and again in a cycle that carries `wr_ack`. A cycle-by-cycle model, in which the abort wins, judges the result: no pulse may appear, the block must be idle one cycle later, and the following `start` must begin with a fresh first read. The same priority is checked for `start` and `abort` arriving together while the block is idle.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_FIRST  = 2'd1,
        ST_RD_SECOND = 2'd2,
        ST_RST_WR    = 2'd3
    } ftp_state_e;

    typedef struct packed {
        ftp_state_e st;
        logic       ref_tog;   // toggle bit from the first read of a pair
        logic       confirm;   // a timeout-triggered confirming pair is running
        logic       done;
        logic       pass;
        logic       fail;
    } ftp_regs_t;

endpackage

// File: rtl/ftp_pair_eval.sv
// Pulls the toggle and timeout bits out of a status word and compares the toggle bit
// with the stored reference value.
module ftp_pair_eval #(
    parameter int DATA_W  = 16,
    parameter int TOG_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic [DATA_W-1:0] word,
    input  logic              ref_tog,
    output logic              tog_now,
    output logic              steady,
    output logic              timed_out
);
    localparam logic [DATA_W-1:0] KEEP_MASK =
        (DATA_W'(1) << TOG_BIT) | (DATA_W'(1) << TMO_BIT);

    // Bits that carry no status are dropped on purpose.
    logic [DATA_W-1:0] unused_bits;
    assign unused_bits = word & ~KEEP_MASK;

    assign tog_now   = word[TOG_BIT];
    assign timed_out = word[TMO_BIT];
    assign steady    = (word[TOG_BIT] == ref_tog);
endmodule

// File: rtl/ftp_pair_limit.sv
// Counts consecutive toggling pairs that show no timeout; expire is raised on the
// bump that reaches the limit. MAX_PAIRS = 0 disables the limit.
module ftp_pair_limit #(
    parameter int MAX_PAIRS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic expire
);
    localparam int CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(MAX_PAIRS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (bump) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (MAX_PAIRS == 0) begin : g_unlimited
            logic unused_cnt;
            assign unused_cnt = ^{cnt_q, LAST};
            assign expire     = 1'b0;
        end else begin : g_limited
            assign expire = bump && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
    import ftp_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter int              TOG_BIT   = 6,
    parameter int              TMO_BIT   = 5,
    parameter int              MAX_PAIRS = 8,
    parameter logic [DATA_W-1:0] RST_CMD = DATA_W'(16'h00F0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    input  logic              wr_ack,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    ftp_regs_t r_d, r_q;

    logic tog_now, steady, timed_out;
    logic cnt_clr, cnt_bump, cnt_expire;

    ftp_pair_eval #(
        .DATA_W (DATA_W),
        .TOG_BIT(TOG_BIT),
        .TMO_BIT(TMO_BIT)
    ) u_eval (
        .word     (rd_data),
        .ref_tog  (r_q.ref_tog),
        .tog_now  (tog_now),
        .steady   (steady),
        .timed_out(timed_out)
    );

    ftp_pair_limit #(
        .MAX_PAIRS(MAX_PAIRS)
    ) u_limit (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .bump  (cnt_bump),
        .expire(cnt_expire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.pass = 1'b0;
        r_d.fail = 1'b0;
        cnt_clr  = 1'b0;
        cnt_bump = 1'b0;

        if (abort) begin
            r_d.st      = ST_IDLE;
            r_d.ref_tog = 1'b0;
            r_d.confirm = 1'b0;
            cnt_clr     = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (start) begin
                        r_d.st      = ST_RD_FIRST;
                        r_d.confirm = 1'b0;
                        cnt_clr     = 1'b1;
                    end
                end
                ST_RD_FIRST: begin
                    if (rd_ack) begin
                        r_d.ref_tog = tog_now;
                        r_d.st      = ST_RD_SECOND;
                    end
                end
                ST_RD_SECOND: begin
                    if (rd_ack) begin
                        if (steady) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                            r_d.pass = 1'b1;
                        end else if (r_q.confirm) begin
                            r_d.st = ST_RST_WR;
                        end else if (timed_out) begin
                            r_d.confirm = 1'b1;
                            r_d.st      = ST_RD_FIRST;
                        end else begin
                            cnt_bump = 1'b1;
                            r_d.st   = cnt_expire ? ST_RST_WR : ST_RD_FIRST;
                        end
                    end
                end
                ST_RST_WR: begin
                    if (wr_ack) begin
                        r_d.st      = ST_IDLE;
                        r_d.confirm = 1'b0;
                        r_d.done    = 1'b1;
                        r_d.fail    = 1'b1;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.ref_tog <= 1'b0;
            r_q.confirm <= 1'b0;
            r_q.done    <= 1'b0;
            r_q.pass    <= 1'b0;
            r_q.fail    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req  = (r_q.st == ST_RD_FIRST) || (r_q.st == ST_RD_SECOND);
    assign wr_req  = (r_q.st == ST_RST_WR);
    assign wr_data = RST_CMD;
    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign pass    = r_q.pass;
    assign fail    = r_q.fail;
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              abort,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              wr_req,
    input logic              wr_ack,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail
);
    // R10: never both request kinds at once
    p_req_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    // R10: done accompanies exactly one verdict
    p_done_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done == $countones({pass, fail}) && $onehot0({pass, fail}));

    // R2: a pending read request stays up until acknowledged
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !abort) |=> rd_req);

    // R6: a pending write request stays up until acknowledged, with the command value
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !abort) |=> wr_req);
    p_wr_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_data == DATA_W'(16'h00F0)));

    // R6: a fail pulse follows an acknowledged reset write
    p_fail_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(wr_req && wr_ack && !abort));

    // R3: a pass pulse follows an acknowledged read
    p_pass_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass) |-> $past(rd_req && rd_ack && !abort));

    // R8: abort leaves the block idle and silent
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !rd_req && !wr_req && !done));

    // R2: start from idle raises a read request
    p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !abort) |=> (rd_req && busy));

    // R3/R6: pulses last a single cycle
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind flash_toggle_poller ftp_checker #(.DATA_W(DATA_W)) u_ftp_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .abort  (abort),
    .rd_req (rd_req),
    .rd_ack (rd_ack),
    .wr_req (wr_req),
    .wr_ack (wr_ack),
    .wr_data(wr_data),
    .busy   (busy),
    .done   (done),
    .pass   (pass),
    .fail   (fail)
);

// File: tb/flash_toggle_poller_test.sv
`timescale 1ns/1ps
module flash_toggle_poller_test;
    localparam int LIM = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0, rd_ack = 1'b0, wr_ack = 1'b0;
    logic [15:0] rd_data = 16'h0;
    logic        rd_req, wr_req, busy, done, pass, fail;
    logic [15:0] wr_data;

    int    vectors = 0;
    int    misses  = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    flash_toggle_poller #(.MAX_PAIRS(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data),
        .busy(busy), .done(done), .pass(pass), .fail(fail)
    );

    // Behavioural reference: phase 0 idle, 1 awaiting first read, 2 awaiting second,
    // 3 awaiting write acknowledge.
    int phase = 0;
    bit m_ref = 0, m_conf = 0, m_done = 0, m_pass = 0, m_fail = 0;
    int quiet_pairs = 0;

    always @(posedge clk) begin
        m_done = 0; m_pass = 0; m_fail = 0;
        if (!rst_n) begin
            phase = 0; m_ref = 0; m_conf = 0; quiet_pairs = 0;
        end else if (abort) begin
            phase = 0; m_ref = 0; m_conf = 0; quiet_pairs = 0;
        end else if (phase == 0) begin
            if (start) begin phase = 1; m_conf = 0; quiet_pairs = 0; end
        end else if (phase == 1) begin
            if (rd_ack) begin m_ref = rd_data[6]; phase = 2; end
        end else if (phase == 2) begin
            if (rd_ack) begin
                if (rd_data[6] == m_ref) begin
                    m_done = 1; m_pass = 1; phase = 0;
                end else if (m_conf) begin
                    phase = 3;
                end else if (rd_data[5]) begin
                    m_conf = 1; phase = 1;
                end else begin
                    quiet_pairs++;
                    phase = (quiet_pairs >= LIM) ? 3 : 1;
                end
            end
        end else begin
            if (wr_ack) begin m_done = 1; m_fail = 1; phase = 0; m_conf = 0; end
        end
    end

    task automatic cmp1(input string nm, input logic act, input logic exp);
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, nm, act, exp, $time);
        end
    endtask

    task automatic compare();
        vectors++;
        cmp1("rd_req", rd_req, phase == 1 || phase == 2);
        cmp1("wr_req", wr_req, phase == 3);
        cmp1("busy",   busy,   phase != 0);
        cmp1("done",   done,   m_done);
        cmp1("pass",   pass,   m_pass);
        cmp1("fail",   fail,   m_fail);
        if (wr_req === 1'b1 && wr_data !== 16'h00F0) begin
            misses++;
            $display("FAIL R6 wr_data: actual %h expected 00f0", wr_data);
        end
    endtask

    task automatic step(input logic s, input logic a, input logic ra,
                        input logic [15:0] rd, input logic wa);
        @(negedge clk);
        compare();
        start = s; abort = a; rd_ack = ra; rd_data = rd; wr_ack = wa;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 16'h0, 0);
    endtask

    task automatic rd(input logic [15:0] w, input int waits);
        for (int i = 0; i < waits; i++) step(0, 0, 0, 16'hFFFF, 0);
        step(0, 0, 1, w, 0);
    endtask

    task automatic wr(input int waits);
        for (int i = 0; i < waits; i++) step(0, 0, 0, 16'h0, 0);
        step(0, 0, 0, 16'h0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        idle(2);
        rst_n = 1'b1;
        idle(3);

        // R2/R3: steady toggle bit, acknowledges delayed, unrelated bits vary
        cur_req = "R3";
        step(1, 0, 0, 16'h0, 0);
        rd(16'hA5C0, 2);
        rd(16'h5A40, 1);
        idle(3);

        // R4: toggling with timeout bit low, then a steady new pair
        cur_req = "R4";
        step(1, 0, 0, 16'h0, 0);
        rd(16'h0040, 0);
        rd(16'h0000, 0);
        rd(16'h0000, 1);
        rd(16'h0000, 0);
        idle(2);

        // R5: timeout bit seen, confirming pair steady -> pass
        cur_req = "R5";
        step(1, 0, 0, 16'h0, 0);
        rd(16'h0040, 0);
        rd(16'h0020, 0);
        rd(16'h0060, 0);
        rd(16'h0060, 0);
        idle(2);

        // R6: confirming pair still toggling -> reset write -> fail
        cur_req = "R6";
        step(1, 0, 0, 16'h0, 0);
        rd(16'h0040, 0);
        rd(16'h0020, 0);
        rd(16'h0060, 1);
        rd(16'h0020, 0);
        wr(3);
        idle(3);

        // R7: LIM toggling pairs without timeout -> reset write -> fail
        cur_req = "R7";
        step(1, 0, 0, 16'h0, 0);
        for (int p = 0; p < LIM; p++) begin
            rd(16'h0040, 0);
            rd(16'h0000, 0);
        end
        wr(0);
        idle(2);

        // R7: a confirming pass just under the limit
        step(1, 0, 0, 16'h0, 0);
        for (int p = 0; p < LIM - 1; p++) begin
            rd(16'h0000, 0);
            rd(16'h0040, 0);
        end
        rd(16'h0040, 0);
        rd(16'h0040, 0);
        idle(2);

        // R8: abort in the cycle of the second acknowledge, then fresh start
        cur_req = "R8";
        step(1, 0, 0, 16'h0, 0);
        rd(16'h0040, 0);
        step(0, 1, 1, 16'h0040, 0);
        idle(2);
        step(1, 0, 0, 16'h0, 0);
        rd(16'h0000, 0);
        rd(16'h0000, 0);
        idle(2);
        // abort in the cycle of the write acknowledge
        step(1, 0, 0, 16'h0, 0);
        rd(16'h0040, 0);
        rd(16'h0020, 0);
        rd(16'h0000, 0);
        rd(16'h0040, 0);
        step(0, 0, 0, 16'h0, 0);
        step(0, 1, 0, 16'h0, 1);
        idle(2);
        // start together with abort while idle
        step(1, 1, 0, 16'h0, 0);
        idle(2);

        // R9: start while busy is ignored
        cur_req = "R9";
        step(1, 0, 0, 16'h0, 0);
        step(1, 0, 0, 16'h0, 0);
        rd(16'h0040, 0);
        step(1, 0, 0, 16'h0, 0);
        rd(16'h0040, 0);
        idle(3);

        // R10: stray acknowledges while idle have no effect
        cur_req = "R10";
        step(0, 0, 1, 16'h0040, 1);
        step(0, 0, 1, 16'h0000, 1);
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule